// File: doc/BRIEF.md
# Serial Flash Command Sequencer

This block runs one serial NOR flash command at a time on a four-line SPI bus. Software loads an opcode register, an address register and a command word, and fills a word-wide data buffer for writes. Writing the command word with its start bit set launches the command. The sequencer then shifts out the opcode and the optional address, spends the optional dummy cycles, and moves the optional data bytes between the buffer and the flash. Single, dual or quad lanes are used per phase, as set by a 3-bit lane-mode code in the command word.

While the command runs, the start bit reads back as 1. It returns to 0 when the sequencer is idle again, at the same moment the complete flag rises, so software can either poll or take an interrupt. Before launch, the address sent on the wire is compared with a programmable protection limit. If it is at or above the limit, the command is dropped without touching the bus and an error flag is raised. Interrupt state is held in raw, mask, masked-status and clear registers.

The register port is a simple synchronous write strobe with a combinational read. Word addresses:

| Address | Register |
|---|---|
| 0x00 | command word |
| 0x01 | opcode |
| 0x02 | address |
| 0x03 | read-only global word |
| 0x04 | raw flags |
| 0x05 | mask |
| 0x06 | masked flags |
| 0x07 | clear |
| 0x08 | protection limit |
| 0x80 + i | buffer word i |

Top module: `sfc_seq`

## Requirements
- R1: Command word fields:
  - bit 0 start
  - bits 2:1 chip select
  - bit 3 address enable
  - bits 6:4 dummy byte count
  - bit 7 data enable
  - bit 8 direction (1 = read from flash)
  - bits 16:9 byte count minus one
  - bits 19:17 lane mode

  A write with start set while idle launches a command. Bit 0 of register 0x00 reads 1 while the command runs and 0 afterwards. Raw flag bit 0 (complete) is set when it clears. After reset, every register except the limit (all ones) reads 0.
- R2: The opcode goes out first, MSB first, followed by the address when enabled, MSB first. The address is 4 bytes when input `addr4_strap` is 1 and 3 bytes (bits 23:0) when it is 0. Bit 2 of register 0x03 reflects `addr4_strap`.
- R3: Lane widths as opcode/address/data per lane-mode code:
  - 0 → 1/1/1
  - 1 → 1/1/2
  - 2 → 1/2/2
  - 3 → 2/2/2
  - 4 → 1/1/1
  - 5 → 1/1/4
  - 6 → 1/4/4
  - 7 → 4/4/4

  On one lane, `io_out[0]` drives and `io_in[1]` is sampled. On two lanes, `io[1]` carries the earlier bit of each pair. On four lanes, `io[3]` carries the earliest bit. Unused lanes have `io_oe` = 0.
- R4: Each dummy byte lasts 8 / (data lane width) SCK cycles, with `io_oe` = 0 throughout.
- R5: A write sends byte-count-plus-one bytes from the buffer, starting at buffer byte 0. Byte b is bits 8*(b%4)+7 : 8*(b%4) of word b/4.
- R6: A read samples the lanes on each SCK rise and stores the bytes into the buffer in the same byte order. Buffer bytes beyond the count are left unchanged. The full 256-byte count is supported.
- R7: SCK idles low; outputs change on SCK falling edges and inputs are sampled on rising edges. Only the selected `cs_n` line goes low. It stays low from the first opcode bit to the last data bit, and all lines stay high for at least one SCK period between commands.
- R8: While a command runs, writes to the command word, opcode, address and buffer are ignored, and the wire sequence of the running command is unchanged.
- R9: If the address is enabled and the value sent (masked to 24 bits in 3-byte mode) is at or above the limit register, no chip select falls. Instead, raw bits 5 and 0 are both set the cycle after the launching write. An address one below the limit runs normally.
- R10: The masked flags register reads raw AND mask. `irq` is 1 exactly when that value is non-zero. Writing 1 to a bit of the clear register clears that raw bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| addr4_strap | input | 1 | 1 selects 4-byte addresses |
| sck | output | 1 | Serial clock, half the block clock while active |
| cs_n | output | 4 | Active-low chip selects |
| io_out | output | 4 | Serial data lanes out |
| io_oe | output | 4 | Per-lane output enable |
| io_in | input | 4 | Serial data lanes in |
| irq | output | 1 | Interrupt request |

## Verification
Register reads are combinational, so the bench sees them in the same cycle, half a clock after driving the address. A launching write pulls chip select low at that edge, and the first SCK rise follows one clock later. Each SCK period is two clocks, and the complete flag and the start bit's clearing come two clocks after chip select rises. A protected abort shows its flags one clock after the write. The bench therefore records lanes, output enables and selects at every SCK rise, and compares them with a sequence it builds from the command fields. It polls the start bit before reading flags or buffer words, and drives its flash model's read lanes as a function of the SCK rise index.

// File: rtl/sfc_seq.sv
module sfc_seq #(
  parameter int BUF_WORDS = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [7:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        addr4_strap,
  output logic        sck,
  output logic [3:0]  cs_n,
  output logic [3:0]  io_out,
  output logic [3:0]  io_oe,
  input  logic [3:0]  io_in,
  output logic        irq
);
  localparam int BW = $clog2(BUF_WORDS * 4);
  localparam int WW = BW - 2;

  typedef enum logic [2:0] {S_IDLE, S_OPC, S_ADR, S_DUM, S_DAT, S_GAP} st_t;

  st_t         st, nph;
  logic [19:1] cfg;
  logic [7:0]  opc, bidx, rx, rx_nxt, ld_byte;
  logic [31:0] adr, lim, aval, sh, ldw;
  logic [8:0]  mask, raw, clr;
  logic [31:0] mem [BUF_WORDS];
  logic [5:0]  bits;
  logic [2:0]  wo, wa, wd, w;
  logic [BW-1:0] ld_idx;
  logic        gapc, busy, active, wr_ok, go, abort, launch, last, eng_wr, done, drive;

  wire [1:0] f_sel  = cfg[2:1];
  wire       f_aen  = cfg[3];
  wire [2:0] f_dcnt = cfg[6:4];
  wire       f_den  = cfg[7];
  wire       f_rd   = cfg[8];
  wire [7:0] f_cnt  = cfg[16:9];
  wire [2:0] f_mode = cfg[19:17];

  assign busy   = st != S_IDLE;
  assign active = st == S_OPC || st == S_ADR || st == S_DUM || st == S_DAT;
  assign wr_ok  = reg_wr && !busy;
  assign go     = wr_ok && reg_addr == 8'h00 && reg_wdata[0];
  assign aval   = addr4_strap ? adr : {8'h00, adr[23:0]};
  assign abort  = go && reg_wdata[3] && aval >= lim;
  assign launch = go && !abort;

  assign wo = f_mode == 3'd7 ? 3'd4 : f_mode == 3'd3 ? 3'd2 : 3'd1;
  assign wa = (f_mode == 3'd6 || f_mode == 3'd7) ? 3'd4 :
              (f_mode == 3'd2 || f_mode == 3'd3) ? 3'd2 : 3'd1;
  assign wd = f_mode[2] ? (f_mode[1:0] == 2'd0 ? 3'd1 : 3'd4) :
                          (f_mode == 3'd0 ? 3'd1 : 3'd2);

  always_comb begin
    case (st)
      S_OPC:   w = wo;
      S_ADR:   w = wa;
      default: w = wd;
    endcase
  end

  always_comb begin
    case (st)
      S_OPC:   nph = f_aen ? S_ADR : (f_dcnt != 3'd0 ? S_DUM : (f_den ? S_DAT : S_GAP));
      S_ADR:   nph = f_dcnt != 3'd0 ? S_DUM : (f_den ? S_DAT : S_GAP);
      S_DUM:   nph = f_den ? S_DAT : S_GAP;
      S_DAT:   nph = bidx == f_cnt ? S_GAP : S_DAT;
      default: nph = S_GAP;
    endcase
  end

  assign last    = active && sck && bits == {3'b000, w};
  assign eng_wr  = st == S_DAT && f_rd && last;
  assign done    = st == S_GAP && !gapc;
  assign ld_idx  = st == S_DAT ? bidx[BW-1:0] + 1'b1 : '0;
  assign ldw     = mem[ld_idx[BW-1:2]];
  assign ld_byte = ldw[{ld_idx[1:0], 3'b000} +: 8];
  assign rx_nxt  = w == 3'd4 ? {rx[3:0], io_in} :
                   w == 3'd2 ? {rx[5:0], io_in[1:0]} : {rx[6:0], io_in[1]};

  assign drive  = st == S_OPC || st == S_ADR || (st == S_DAT && !f_rd);
  assign io_oe  = !drive ? 4'h0 : w == 3'd4 ? 4'hF : w == 3'd2 ? 4'h3 : 4'h1;
  assign io_out = io_oe & (w == 3'd4 ? sh[31:28] :
                           w == 3'd2 ? {2'b00, sh[31:30]} : {3'b000, sh[31]});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cfg <= '0; opc <= '0; adr <= '0; lim <= '1; mask <= '0;
      sh <= '0; bits <= '0; bidx <= '0; rx <= '0; gapc <= 1'b0;
      sck <= 1'b0; cs_n <= 4'hF;
    end else begin
      if (wr_ok && reg_addr == 8'h00) cfg <= reg_wdata[19:1];
      if (wr_ok && reg_addr == 8'h01) opc <= reg_wdata[7:0];
      if (wr_ok && reg_addr == 8'h02) adr <= reg_wdata;
      if (reg_wr && reg_addr == 8'h05) mask <= reg_wdata[8:0];
      if (reg_wr && reg_addr == 8'h08) lim <= reg_wdata;
      if (launch) begin
        st   <= S_OPC;
        sh   <= {opc, 24'h0};
        bits <= 6'd8;
        sck  <= 1'b0;
        cs_n <= ~(4'b0001 << reg_wdata[2:1]);
      end else if (active) begin
        if (!sck) begin
          sck <= 1'b1;
          if (st == S_DAT && f_rd) rx <= rx_nxt;
        end else begin
          sck  <= 1'b0;
          sh   <= sh << w;
          bits <= bits - {3'b000, w};
          if (last) begin
            st <= nph;
            case (nph)
              S_ADR: begin
                sh   <= addr4_strap ? adr : {adr[23:0], 8'h00};
                bits <= addr4_strap ? 6'd32 : 6'd24;
              end
              S_DUM: bits <= {f_dcnt, 3'b000};
              S_DAT: begin
                sh   <= {ld_byte, 24'h0};
                bits <= 6'd8;
                bidx <= st == S_DAT ? bidx + 8'd1 : 8'd0;
              end
              default: begin
                cs_n <= 4'hF;
                gapc <= 1'b1;
              end
            endcase
          end
        end
      end else if (st == S_GAP) begin
        if (gapc) gapc <= 1'b0;
        else st <= S_IDLE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok && reg_addr[7]) mem[reg_addr[WW-1:0]] <= reg_wdata;
    else if (eng_wr) mem[bidx[BW-1:2]][{bidx[1:0], 3'b000} +: 8] <= rx;
  end

  assign clr = (reg_wr && reg_addr == 8'h07) ? reg_wdata[8:0] : 9'h000;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw <= '0;
    else raw <= (raw & ~clr) | {3'b000, abort, 4'b0000, done | abort};
  end

  assign irq = |(raw & mask);

  always_comb begin
    reg_rdata = 32'h0;
    if (reg_addr[7]) reg_rdata = mem[reg_addr[WW-1:0]];
    else case (reg_addr)
      8'h00: reg_rdata = {12'h000, cfg, busy};
      8'h01: reg_rdata = {24'h0, opc};
      8'h02: reg_rdata = adr;
      8'h03: reg_rdata = {29'h0, addr4_strap, 2'b00};
      8'h04: reg_rdata = {23'h0, raw};
      8'h05: reg_rdata = {23'h0, mask};
      8'h06: reg_rdata = {23'h0, raw & mask};
      8'h08: reg_rdata = lim;
      default: reg_rdata = 32'h0;
    endcase
  end
endmodule

// File: rtl/sfc_seq_chk.sv
module sfc_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sck,
  input logic [3:0] cs_n,
  input logic [3:0] io_oe,
  input logic [2:0] st,
  input logic       reg_wr,
  input logic [7:0] reg_addr,
  input logic [7:0] opc,
  input logic [8:0] raw
);
  logic busy;
  assign busy = st != 3'd0;

  assert_cs_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~cs_n) <= 1);
  assert_sck_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (&cs_n) |-> !sck);
  assert_dummy_float_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd3) |-> io_oe == 4'h0);
  assert_busy_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wr && reg_addr == 8'h01) |=> $stable(opc));
  assert_done_flag_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> raw[0]);
  assert_abort_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(raw[5]) |-> &cs_n);
endmodule

bind sfc_seq sfc_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .io_oe(io_oe),
  .st(st), .reg_wr(reg_wr), .reg_addr(reg_addr), .opc(opc), .raw(raw)
);

// File: tb/sim_sfc_seq.sv
`timescale 1ns/1ps
module sim_sfc_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [7:0] reg_addr = 8'h0;
  logic [31:0] reg_wdata = 32'h0, reg_rdata;
  logic addr4_strap = 1'b0;
  logic sck, irq;
  logic [3:0] cs_n, io_out, io_oe, io_in;

  always #10 clk = ~clk;

  sfc_seq u0 (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .addr4_strap(addr4_strap),
    .sck(sck), .cs_n(cs_n), .io_out(io_out), .io_oe(io_oe), .io_in(io_in), .irq(irq));

  int checks = 0, errors = 0;
  int rc = 0, ne = 0;
  logic [3:0] cap_v [4096], cap_oe [4096], cap_cs [4096];
  logic [3:0] ev [4096], eo [4096];
  logic [7:0] bufm [256];
  bit cs_seen = 0;
  int hi_run = 0, min_gap = 1000;

  function automatic logic [3:0] hf(int k);
    int t = k * 5 + (k >> 3) * 3 + 1;
    return t[3:0];
  endfunction

  assign io_in = hf(rc);

  always @(posedge sck) begin
    if (rc < 4096) begin
      cap_v[rc] = io_out; cap_oe[rc] = io_oe; cap_cs[rc] = cs_n;
    end
    rc = rc + 1;
  end

  always @(cs_n) if (cs_n != 4'hF) cs_seen = 1;

  always @(posedge clk) begin
    if (&cs_n) hi_run++;
    else begin
      if (hi_run > 0 && hi_run < min_gap) min_gap = hi_run;
      hi_run = 0;
    end
  end

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic bus_rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  function automatic int fo(int m); return m == 7 ? 4 : m == 3 ? 2 : 1; endfunction
  function automatic int fa(int m); return (m == 6 || m == 7) ? 4 : (m == 2 || m == 3) ? 2 : 1; endfunction
  function automatic int fd(int m); return m >= 5 ? 4 : (m >= 1 && m <= 3) ? 2 : 1; endfunction

  task automatic push_out(logic [31:0] v, int nb, int w);
    for (int i = 0; i < nb; i += w) begin
      ev[ne] = w == 1 ? {3'b0, v[31]} : w == 2 ? {2'b0, v[31:30]} : v[31:28];
      eo[ne] = w == 1 ? 4'h1 : w == 2 ? 4'h3 : 4'hF;
      v = v << w; ne++;
    end
  endtask

  function automatic logic [31:0] word_of(int i);
    return {bufm[4*i+3], bufm[4*i+2], bufm[4*i+1], bufm[4*i]};
  endfunction

  task automatic launch(logic [7:0] op, logic [31:0] ad, int m, bit aen, int dc,
                        bit den, bit rd, int n, int sel);
    logic [31:0] cfg;
    if (den && !rd) for (int i = 0; i < (n + 3) / 4; i++) bus_wr(8'h80 + 8'(i), word_of(i));
    ne = 0;
    push_out({op, 24'h0}, 8, fo(m));
    if (aen) push_out(addr4_strap ? ad : {ad[23:0], 8'h0}, addr4_strap ? 32 : 24, fa(m));
    for (int i = 0; i < dc * 8 / fd(m); i++) begin ev[ne] = 0; eo[ne] = 0; ne++; end
    if (den) for (int b = 0; b < n; b++) begin
      if (rd) begin
        logic [7:0] acc = 8'h0;
        for (int j = 0; j < 8 / fd(m); j++) begin
          logic [3:0] l = hf(ne);
          acc = fd(m) == 1 ? {acc[6:0], l[1]} : fd(m) == 2 ? {acc[5:0], l[1:0]} : {acc[3:0], l};
          ev[ne] = 0; eo[ne] = 0; ne++;
        end
        bufm[b] = acc;
      end else push_out({bufm[b], 24'h0}, 8, fd(m));
    end
    rc = 0; cs_seen = 0;
    bus_wr(8'h01, {24'h0, op});
    bus_wr(8'h02, ad);
    cfg = (32'(m) << 17) | (32'(n - 1) << 9) | (32'(rd) << 8) | (32'(den) << 7) |
          (32'(dc) << 4) | (32'(aen) << 3) | (32'(sel) << 1) | 32'h1;
    bus_wr(8'h00, cfg);
  endtask

  task automatic wait_idle;
    logic [31:0] d;
    for (int i = 0; i < 20000; i++) begin
      bus_rd(8'h00, d);
      if (!d[0]) break;
    end
  endtask

  task automatic finish_cmd(string tag, bit den, bit rd, int n, int sel);
    logic [31:0] d;
    int bad = 0, csbad = 0;
    wait_idle();
    bus_rd(8'h00, d);
    chk(d[0] == 1'b0, {tag, " R1 start cleared"}, d[0], 0);
    bus_rd(8'h04, d);
    chk(d[0] == 1'b1, {tag, " R1 complete flag"}, d, 1);
    bus_wr(8'h07, 32'h1FF);
    chk(rc == ne, {tag, " R4 SCK count"}, rc, ne);
    for (int k = 0; k < ne && k < 4096; k++) begin
      if (cap_oe[k] != eo[k] || (cap_v[k] & eo[k]) != (ev[k] & eo[k])) bad++;
      if (cap_cs[k] != ~(4'b0001 << sel)) csbad++;
    end
    chk(bad == 0, {tag, " R2 R3 R5 wire lanes"}, bad, 0);
    chk(csbad == 0, {tag, " R7 chip select"}, csbad, 0);
    if (den && rd) begin
      bad = 0;
      for (int i = 0; i < 64; i++) begin
        bus_rd(8'h80 + 8'(i), d);
        if (d != word_of(i)) bad++;
      end
      chk(bad == 0, {tag, " R6 buffer contents"}, bad, 0);
    end
  endtask

  task automatic run_cmd(string tag, logic [7:0] op, logic [31:0] ad, int m, bit aen,
                         int dc, bit den, bit rd, int n, int sel);
    launch(op, ad, m, aen, dc, den, rd, n, sel);
    finish_cmd(tag, den, rd, n, sel);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h5EED));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    bus_rd(8'h00, d); chk(d == 0, "R1 reset command word", d, 0);
    bus_rd(8'h04, d); chk(d == 0, "R10 reset raw flags", d, 0);
    chk(irq == 0 && cs_n == 4'hF && sck == 0, "R7 reset pins", {irq, cs_n, sck}, 32'h1E);
    bus_rd(8'h08, d); chk(d == 32'hFFFF_FFFF, "R9 reset limit", d, 32'hFFFF_FFFF);
    bus_rd(8'h03, d); chk(d == 32'h0, "R2 strap clear", d, 0);
    addr4_strap = 1'b1;
    bus_rd(8'h03, d); chk(d == 32'h4, "R2 strap set", d, 4);
    addr4_strap = 1'b0;

    for (int i = 0; i < 256; i++) bufm[i] = 8'($urandom);
    for (int i = 0; i < 64; i++) bus_wr(8'h80 + 8'(i), word_of(i));

    run_cmd("id read", 8'h9F, 0, 0, 0, 0, 1, 1, 3, 0);
    run_cmd("3byte read", 8'h03, 32'hAB12_3456, 0, 1, 0, 1, 1, 9, 1);
    addr4_strap = 1'b1;
    run_cmd("4byte write", 8'h12, 32'hAB12_3456, 0, 1, 0, 1, 0, 7, 2);
    for (int m = 0; m < 8; m++) begin
      run_cmd($sformatf("mode %0d write R3", m), 8'hA5, 32'h1357_9BDF, m, 1, 1, 1, 0, 5, 3);
      run_cmd($sformatf("mode %0d read R3", m), 8'h6B, 32'h0246_8ACE, m, 1, 3, 1, 1, 6, m % 4);
    end
    run_cmd("max dummy R4", 8'h0B, 32'h10, 1, 1, 7, 1, 1, 4, 0);
    run_cmd("opcode only", 8'h06, 0, 7, 0, 0, 0, 0, 1, 1);
    run_cmd("full quad read R6", 8'hEB, 32'h20, 6, 1, 2, 1, 1, 256, 0);
    addr4_strap = 1'b0;

    launch(8'h02, 32'h400, 0, 1, 0, 1, 0, 16, 1);
    repeat (40) @(negedge clk);
    bus_wr(8'h01, 32'h5A); bus_wr(8'h02, 32'hFFFF); bus_wr(8'h80, ~word_of(0));
    bus_wr(8'h00, 32'h000E_0001);
    finish_cmd("busy writes R8", 1, 0, 16, 1);
    bus_rd(8'h01, d); chk(d == 32'h02, "R8 opcode held", d, 2);
    bus_rd(8'h80, d); chk(d == word_of(0), "R8 buffer held", d, word_of(0));

    bus_wr(8'h08, 32'h1000);
    rc = 0; cs_seen = 0;
    bus_wr(8'h01, 32'h03); bus_wr(8'h02, 32'hFF00_1000); bus_wr(8'h00, 32'h0000_0189);
    bus_rd(8'h04, d); chk(d == 32'h21, "R9 abort flags", d, 32'h21);
    chk(cs_seen == 0 && rc == 0, "R9 no bus activity", {cs_seen, rc[7:0]}, 0);
    bus_rd(8'h00, d); chk(d[0] == 0, "R9 start clear", d[0], 0);
    bus_wr(8'h07, 32'h1FF);
    run_cmd("below limit R9", 8'h03, 32'h0FFF, 0, 1, 0, 1, 1, 2, 0);

    run_cmd("irq source R10", 8'h05, 0, 0, 0, 0, 1, 1, 1, 0);
    launch(8'h05, 0, 0, 0, 0, 1, 1, 1, 0); wait_idle();
    bus_wr(8'h05, 32'h0);
    chk(irq == 0, "R10 masked irq", irq, 0);
    bus_rd(8'h06, d); chk(d == 0, "R10 masked status", d, 0);
    bus_wr(8'h05, 32'h1);
    chk(irq == 1, "R10 unmasked irq", irq, 1);
    bus_rd(8'h06, d); chk(d == 1, "R10 status value", d, 1);
    bus_wr(8'h07, 32'h1);
    bus_rd(8'h04, d); chk(d == 0 && irq == 0, "R10 clear", {d[30:0], irq}, 0);
    bus_wr(8'h05, 32'h0); bus_wr(8'h08, 32'hFFFF_FFFF);

    for (int t = 0; t < 25; t++) begin
      int m = int'($urandom % 8), dc = int'($urandom % 8), n = 1 + int'($urandom % 32);
      bit aen = 1'($urandom), den = 1'($urandom), rd = 1'($urandom);
      addr4_strap = 1'($urandom);
      run_cmd($sformatf("random %0d", t), 8'($urandom), $urandom, m, aen, dc, den, rd, n,
              int'($urandom % 4));
    end
    chk(min_gap >= 2, "R7 deselect gap", min_gap, 2);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule